// File: doc/BRIEF.md
# Cross-Plane Message Smoothing Unit

This unit sits at the back end of a belief-propagation message update. Each cycle it may accept one new candidate message for every depth plane, all for the same pixel and direction. It applies a truncated-linear smoothness limit across those planes. It finds the smallest candidate over all planes, raises that floor by a programmable truncation constant, and caps every plane's candidate at the raised floor. The capped vector is what the surrounding datapath writes back into its message stores.

The unit is fully pipelined and accepts a new vector on every cycle. The minimum search is a balanced binary comparator tree with one register stage per level. When the plane count is not a power of two, the unused leaves are filled with the all-ones value, so they can never win the search. The truncation constant is added with saturation at the all-ones value. A result leaves the unit exactly 2 + ceil(log2(NPLANE)) cycles after its inputs arrive. The truncation constant applied to a vector is the one present on the same cycle as its candidates.

Top module: `msg_clamp_unit`

## Requirements
- R1: When `in_valid` is high on a clock edge, `out_valid` is high after the edge that comes exactly LAT = 2 + ceil(log2(NPLANE)) edges later (5 for the default of 5 planes). Back-to-back and gapped inputs each produce exactly one valid output, in order, and `out_valid` is low in every other cycle.
- R2: For a valid output, plane p (element p of the packed arrays, plane 0 in the least significant DW bits) equals min(cand[p], S), where S is the minimum of all NPLANE candidates plus `trunc_d`, and all values are unsigned.
- R3: The minimum covers every plane, including the highest-numbered one, and the all-ones padding of a non-power-of-two tree never replaces a real candidate.
- R4: The sum of minimum and `trunc_d` saturates at 2^DW-1 and never wraps. When it saturates, every output equals its candidate.
- R5: The `trunc_d` value applied to a vector is the one sampled on the same edge as that vector's candidates, even when `trunc_d` changes on every cycle.
- R6: While `rst_n` is low, and after it is released until the first valid result, `out_valid` is 0 and `out_msg` is all zero.
- R7: With `trunc_d` = 0, every plane of the output equals the global minimum of the candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Candidate vector present this cycle |
| in_cand | input | NPLANE*DW | Candidate message per plane, plane p at bits [p*DW +: DW] |
| trunc_d | input | DW | Truncation constant added to the cross-plane minimum |
| out_valid | output | 1 | Clamped vector present this cycle |
| out_msg | output | NPLANE*DW | Clamped message per plane, same layout as the input |

## Verification
The bench puts the lone minimum in each plane in turn, the highest-numbered plane among them. A tree that dropped the last plane or let its all-ones padding win would then clamp to the wrong floor. It drives candidates close to the top of the range together with large truncation values. A wrapping adder would then clamp everything to a small number instead of passing the candidates through. It changes the truncation value on every cycle, which exposes a constant that is not aligned with its vector, and it uses zero truncation, where every plane must collapse to the minimum. Sparse valid patterns catch a valid pipeline one stage too short or too long, because each output would then pair with the wrong vector or show up in the wrong cycle.

// File: rtl/msg_clamp_pkg.sv
package msg_clamp_pkg;

  // Number of comparator levels needed to reduce n values to one.
  function automatic int clamp_levels(input int n);
    int lv;
    lv = 0;
    while ((1 << lv) < n) lv++;
    return lv;
  endfunction

  // Edge count from input to output: tree levels, offset stage, cap stage.
  function automatic int clamp_latency(input int n);
    return clamp_levels(n) + 2;
  endfunction

endpackage

// File: rtl/msg_pipe_delay.sv
module msg_pipe_delay #(
  parameter int DEPTH = 1,
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_regs
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
      end else begin
        stage_q[0] <= d_i;
        for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
      end
    end

    assign q_o = stage_q[DEPTH-1];
  end

endmodule

// File: rtl/msg_min_tree.sv
module msg_min_tree
  import msg_clamp_pkg::*;
#(
  parameter int NPLANE = 5,
  parameter int DW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPLANE-1:0][DW-1:0]  leaf_i,
  output logic [DW-1:0]              min_o
);

  localparam int LVLS  = clamp_levels(NPLANE);
  localparam int NLEAF = 1 << LVLS;

  function automatic logic [DW-1:0] pick_min(input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    return (b < a) ? b : a;
  endfunction

  logic [DW-1:0] leaf [NLEAF];

  // Leaves past the last real plane hold the largest value so they never win.
  for (genvar gi = 0; gi < NLEAF; gi++) begin : g_leaf
    if (gi < NPLANE) begin : g_real
      assign leaf[gi] = leaf_i[gi];
    end else begin : g_pad
      assign leaf[gi] = {DW{1'b1}};
    end
  end

  if (LVLS == 0) begin : g_single
    assign min_o = leaf[0];
  end else begin : g_tree
    // Heap order: node h (1..NLEAF-1) is stored at index h-1, root is h = 1.
    logic [DW-1:0] node_q [NLEAF-1];

    for (genvar gn = 1; gn < NLEAF; gn++) begin : g_node
      logic [DW-1:0] lhs;
      logic [DW-1:0] rhs;
      if (2 * gn >= NLEAF) begin : g_from_leaf
        assign lhs = leaf[2*gn - NLEAF];
        assign rhs = leaf[2*gn + 1 - NLEAF];
      end else begin : g_from_node
        assign lhs = node_q[2*gn - 1];
        assign rhs = node_q[2*gn];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) node_q[gn-1] <= '0;
        else        node_q[gn-1] <= pick_min(lhs, rhs);
      end
    end

    assign min_o = node_q[0];
  end

endmodule

// File: rtl/msg_clamp_stage.sv
module msg_clamp_stage #(
  parameter int NPLANE = 5,
  parameter int DW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              root_min,
  input  logic                       root_valid,
  input  logic [DW-1:0]              d_al,
  input  logic [NPLANE-1:0][DW-1:0]  cand_al,
  output logic [DW-1:0]              offset_min,
  output logic                       offset_valid,
  output logic                       out_valid,
  output logic [NPLANE-1:0][DW-1:0]  out_msg
);

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a,
                                            input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW] ? {DW{1'b1}} : s[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] cap(input logic [DW-1:0] v,
                                        input logic [DW-1:0] lim);
    return (v < lim) ? v : lim;
  endfunction

  // Offset stage: raised floor.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_min   <= '0;
      offset_valid <= 1'b0;
    end else begin
      offset_min   <= sat_add(root_min, d_al);
      offset_valid <= root_valid;
    end
  end

  // Cap stage: each plane limited by the raised floor.
  for (genvar gp = 0; gp < NPLANE; gp++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_msg[gp] <= '0;
      else        out_msg[gp] <= cap(cand_al[gp], offset_min);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= offset_valid;
  end

endmodule

// File: rtl/msg_clamp_unit.sv
module msg_clamp_unit
  import msg_clamp_pkg::*;
#(
  parameter int NPLANE = 5,
  parameter int DW     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [NPLANE-1:0][DW-1:0] in_cand,
  input  logic [DW-1:0]             trunc_d,
  output logic                      out_valid,
  output logic [NPLANE-1:0][DW-1:0] out_msg
);

  localparam int LVLS = clamp_levels(NPLANE);
  localparam int LAT  = clamp_latency(NPLANE);

  // Named internal events, observed by the bound checker.
  logic [DW-1:0]              root_min;
  logic                       root_valid;
  logic [DW-1:0]              d_al;
  logic [DW-1:0]              offset_min;
  logic                       offset_valid;
  logic [NPLANE*DW-1:0]       cand_flat_in;
  logic [NPLANE*DW-1:0]       cand_flat_dly;
  logic [NPLANE-1:0][DW-1:0]  cand_al;

  assign cand_flat_in = in_cand;
  assign cand_al      = cand_flat_dly;

  msg_min_tree #(.NPLANE(NPLANE), .DW(DW)) u_tree (
    .clk    (clk),
    .rst_n  (rst_n),
    .leaf_i (in_cand),
    .min_o  (root_min)
  );

  // Constant follows its vector through the tree levels.
  msg_pipe_delay #(.DEPTH(LVLS), .WIDTH(DW)) u_d_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (trunc_d),
    .q_o   (d_al)
  );

  msg_pipe_delay #(.DEPTH(LVLS), .WIDTH(1)) u_vld_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (in_valid),
    .q_o   (root_valid)
  );

  // Candidates wait for the tree and the offset stage.
  msg_pipe_delay #(.DEPTH(LVLS + 1), .WIDTH(NPLANE * DW)) u_cand_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cand_flat_in),
    .q_o   (cand_flat_dly)
  );

  msg_clamp_stage #(.NPLANE(NPLANE), .DW(DW)) u_stage (
    .clk          (clk),
    .rst_n        (rst_n),
    .root_min     (root_min),
    .root_valid   (root_valid),
    .d_al         (d_al),
    .cand_al      (cand_al),
    .offset_min   (offset_min),
    .offset_valid (offset_valid),
    .out_valid    (out_valid),
    .out_msg      (out_msg)
  );

  if (LAT < 2) begin : g_bad_lat
    initial $error("latency below two stages");
  end

endmodule

// File: rtl/msg_clamp_chk.sv
module msg_clamp_chk
  import msg_clamp_pkg::*;
#(
  parameter int NPLANE = 5,
  parameter int DW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic [NPLANE-1:0][DW-1:0] out_msg,
  input logic [DW-1:0]             root_min,
  input logic                      root_valid,
  input logic [DW-1:0]             offset_min,
  input logic                      offset_valid
);

  localparam int LAT = clamp_latency(NPLANE);
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] inflight_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + CW'(in_valid) - CW'(out_valid);
  end

  // R1
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight_q != '0));

  // R1
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CW'(LAT));

  // R1
  stage_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_valid |-> $past(root_valid));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_valid |-> (offset_min >= $past(root_min)));

  for (genvar gp = 0; gp < NPLANE; gp++) begin : g_plane
    // R2
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_msg[gp] <= $past(offset_min)));
  end

endmodule

bind msg_clamp_unit msg_clamp_chk #(.NPLANE(NPLANE), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_msg      (out_msg),
  .root_min     (root_min),
  .root_valid   (root_valid),
  .offset_min   (offset_min),
  .offset_valid (offset_valid)
);

// File: tb/msg_clamp_unit_bench.sv
module msg_clamp_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 5;
  localparam int DW   = 16;
  localparam int LAT  = 5;
  localparam int MAXV = (1 << DW) - 1;

  typedef logic [NP-1:0][DW-1:0] vec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  vec_t          in_cand = '0;
  logic [DW-1:0] trunc_d = '0;
  logic          out_valid;
  vec_t          out_msg;

  int checks = 0;
  int errors = 0;
  string phase_tag = "R1";

  msg_clamp_unit #(.NPLANE(NP), .DW(DW)) u_msg_clamp_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_cand   (in_cand),
    .trunc_d   (trunc_d),
    .out_valid (out_valid),
    .out_msg   (out_msg)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Behavioural expectation: lowest candidate, raised and limited to the top.
  function automatic vec_t ref_out(input vec_t c, input logic [DW-1:0] dd);
    vec_t r;
    int lowest;
    int raised;
    lowest = MAXV;
    for (int p = 0; p < NP; p++) if (int'(c[p]) < lowest) lowest = int'(c[p]);
    raised = lowest + int'(dd);
    if (raised > MAXV) raised = MAXV;
    for (int p = 0; p < NP; p++)
      r[p] = (int'(c[p]) < raised) ? c[p] : DW'(raised);
    return r;
  endfunction

  vec_t  exp_q[$];
  bit    ev_q[$];
  string tag_q[$];
  vec_t  cur_exp = '0;
  bit    cur_v = 1'b0;
  string cur_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      ev_q.delete();
      tag_q.delete();
      cur_v = 1'b0;
    end else begin
      exp_q.push_back(ref_out(in_cand, trunc_d));
      ev_q.push_back(in_valid);
      tag_q.push_back(phase_tag);
      if (ev_q.size() == LAT) begin
        cur_exp = exp_q.pop_front();
        cur_v   = ev_q.pop_front();
        cur_tag = tag_q.pop_front();
      end
    end
  end

  task automatic check_vec(input string tag, input vec_t act, input vec_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_msg actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: out_valid actual %b expected %b", tag, act, exp);
    end
  endtask

  // Compare at the falling edge, then drive the next input.
  task automatic step(input logic v, input vec_t c, input logic [DW-1:0] dd,
                      input string tag);
    @(negedge clk);
    check_bit("R1", out_valid, cur_v);
    if (cur_v) check_vec(cur_tag, out_msg, cur_exp);
    in_valid  = v;
    in_cand   = c;
    trunc_d   = dd;
    phase_tag = tag;
  endtask

  function automatic vec_t rnd_vec(input int base, input int span);
    vec_t c;
    for (int p = 0; p < NP; p++) begin
      int v;
      v = base + int'($urandom_range(0, span));
      if (v > MAXV) v = MAXV;
      c[p] = DW'(v);
    end
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t c;
    // R6: reset state while held and just after release
    repeat (3) @(negedge clk);
    check_bit("R6", out_valid, 1'b0);
    check_vec("R6", out_msg, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R6", out_valid, 1'b0);
    check_vec("R6", out_msg, '0);

    // R2: back-to-back random vectors, random constant
    for (int i = 0; i < 150; i++)
      step(1'b1, rnd_vec(int'($urandom_range(0, 60000)), 3000),
           DW'($urandom_range(0, 2000)), "R2");

    // R5: constant toggles every cycle, candidates fixed
    c = rnd_vec(20000, 1500);
    for (int i = 0; i < 20; i++)
      step(1'b1, c, (i % 2 == 0) ? DW'(0) : DW'(300 + 7 * i), "R5");

    // R7: zero constant collapses all planes to the minimum
    for (int i = 0; i < 20; i++)
      step(1'b1, rnd_vec(int'($urandom_range(0, 50000)), 8000), '0, "R7");

    // R4: sums near and past the top of the range
    for (int i = 0; i < 30; i++)
      step(1'b1, rnd_vec(MAXV - 100, 100),
           (i % 3 == 0) ? DW'(MAXV) : DW'($urandom_range(50, MAXV)), "R4");

    // R3: single low plane at every position, plus all-top vector
    for (int pos = 0; pos < NP; pos++) begin
      c = '1;
      c[pos] = DW'(1000);
      step(1'b1, c, DW'(10), "R3");
    end
    step(1'b1, '1, '0, "R3");
    c = '1;
    c[NP-1] = '0;
    step(1'b1, c, '0, "R3");

    // R1: sparse and gapped valid pattern
    for (int i = 0; i < 200; i++)
      step(1'($urandom_range(0, 1)), rnd_vec(int'($urandom_range(0, 40000)), 5000),
           DW'($urandom_range(0, 4000)), "R1");

    // R1: drain, no further valid outputs
    for (int i = 0; i < LAT + 3; i++) step(1'b0, '0, '0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule